// File: doc/BRIEF.md
# Exception Entry Controller

This block decides which pending exception a processor core enters and computes everything the core needs to do so. Exception sources hold request bits high. At an instruction boundary the controller masks the two interrupt requests with the current status word, picks the highest-priority survivor and, one clock later, presents a one-cycle entry bundle. The bundle holds the new processor mode, the new status word, the status value to save, the return link value and the handler vector address. The controller performs no register writes itself. The valid pulse of the bundle is the write strobe for the banked link register, the saved-status register of the new mode and the live status register.

The bundle is a valid-only stream with no back-pressure. Register-file and status writes always complete in the cycle they are presented, so no ready input exists. Consumers must capture the bundle in the single cycle that `entry_valid_o` is high. A one-hot acknowledge travels with the bundle so that the source of the taken request can drop a level-held request. A strap relocates the vector table from address zero to a high base.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset `entry_valid_o` is 0 and `ack_o`, `new_mode_o`, `new_status_o`, `saved_status_o`, `link_o` and `vector_o` are all zero. A request taken at clock edge k produces a bundle visible after edge k, with `entry_valid_o` high for exactly one cycle.
- R2: Request bit positions are 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 undefined instruction, 6 software interrupt. Among eligible requests the lowest bit position wins. `ack_o` carries the winner's bit alone while the bundle is valid and is zero otherwise.
- R3: Bit 2 of `req_i` is ineligible while `status_i[6]` is 1, and bit 3 is ineligible while `status_i[7]` is 1. Both masks use the status value at the sampling edge.
- R4: Bits 1 to 6 are eligible only at an edge where `boundary_i` is 1. Bit 0 is eligible at any edge. No request is eligible at an edge where `entry_valid_o` is already high, so at most one entry is taken per strobe.
- R5: `vector_o` is the base plus an offset. The base is 0x00000000, or 0xFFFF0000 when `hivec_i` is 1. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R6: `new_mode_o` is 0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for either abort, 0x12 for normal interrupt and 0x11 for fast interrupt. This is also the bank that receives the link and saved values.
- R7: `link_o` is `next_pc_i` for undefined, software interrupt and prefetch abort. It is `next_pc_i + 4` for data abort and both interrupts, and 0 for reset.
- R8: `saved_status_o` is 0 for reset and equals the sampled `status_i` for every other exception.
- R9: In `new_status_o`, bits [4:0] hold the new mode, bit 5 is cleared and bit 7 is set. Bit 6 is set for reset and fast interrupt and keeps its sampled value otherwise.
- R10: `new_status_o[31:8]` equals the sampled `status_i[31:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| req_i | input | 7 | Level-held exception requests, one bit per type |
| status_i | input | 32 | Current status word |
| next_pc_i | input | 32 | Address of the next sequential instruction |
| hivec_i | input | 1 | High vector table strap |
| entry_valid_o | output | 1 | Bundle valid and write strobe, one cycle |
| ack_o | output | 7 | One-hot acknowledge of the taken request |
| new_mode_o | output | 5 | Target mode and bank for the link and saved writes |
| new_status_o | output | 32 | Status word to load |
| saved_status_o | output | 32 | Value for the target mode's saved-status register |
| link_o | output | 32 | Value for the target mode's link register |
| vector_o | output | 32 | Handler address |

## Verification
A wrong busy state shows in the cycle right after a bundle. Either a second pulse appears on a still-held request, or a legal entry goes missing. A wrong winner or a wrong kind decode shows in the same cycle as the valid pulse, as an acknowledge that disagrees with the mode, link offset or vector. Mask and strap mistakes show only when an interrupt coincides with a set status bit, or when the strap is high. Random status words and request mixes therefore cover those crossings on every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int unsigned NUM_EXC = 7;
  localparam int unsigned MODE_W  = 5;
  localparam int unsigned SLOT_W  = 3;

  // Bit position in the request vector equals priority rank.
  typedef enum logic [2:0] {
    EX_RESET = 3'd0,
    EX_DABT  = 3'd1,
    EX_FIQ   = 3'd2,
    EX_IRQ   = 3'd3,
    EX_PABT  = 3'd4,
    EX_UNDEF = 3'd5,
    EX_SWI   = 3'd6
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  localparam int unsigned ST_T = 5;
  localparam int unsigned ST_F = 6;
  localparam int unsigned ST_I = 7;

  function automatic logic [MODE_W-1:0] target_mode(exc_kind_e k);
    logic [MODE_W-1:0] m;
    case (k)
      EX_RESET, EX_SWI: m = MODE_SVC;
      EX_DABT, EX_PABT: m = MODE_ABT;
      EX_FIQ:           m = MODE_FIQ;
      EX_IRQ:           m = MODE_IRQ;
      default:          m = MODE_UND;
    endcase
    return m;
  endfunction

  // Word index of the handler inside the vector table.
  function automatic logic [SLOT_W-1:0] vector_slot(exc_kind_e k);
    logic [SLOT_W-1:0] s;
    case (k)
      EX_RESET: s = 3'd0;
      EX_UNDEF: s = 3'd1;
      EX_SWI:   s = 3'd2;
      EX_PABT:  s = 3'd3;
      EX_DABT:  s = 3'd4;
      EX_IRQ:   s = 3'd6;
      default:  s = 3'd7;
    endcase
    return s;
  endfunction

  function automatic logic link_adds_word(exc_kind_e k);
    return (k == EX_DABT) || (k == EX_IRQ) || (k == EX_FIQ);
  endfunction

  function automatic logic masks_fast(exc_kind_e k);
    return (k == EX_RESET) || (k == EX_FIQ);
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
#(
  parameter int unsigned N = NUM_EXC
) (
  input  logic [N-1:0] req_i,
  input  logic         boundary_i,
  input  logic         busy_i,
  input  logic         fast_masked_i,
  input  logic         norm_masked_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N-1:0] eligible;

  for (genvar g = 0; g < N; g++) begin : g_elig
    if (g == int'(EX_RESET)) begin : g_rst
      assign eligible[g] = req_i[g] & ~busy_i;
    end else if (g == int'(EX_FIQ)) begin : g_fast
      assign eligible[g] = req_i[g] & boundary_i & ~busy_i & ~fast_masked_i;
    end else if (g == int'(EX_IRQ)) begin : g_norm
      assign eligible[g] = req_i[g] & boundary_i & ~busy_i & ~norm_masked_i;
    end else begin : g_sync
      assign eligible[g] = req_i[g] & boundary_i & ~busy_i;
    end
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      grant_o[i] = eligible[i] & ~seen;
      seen       = seen | eligible[i];
    end
  end

  assign any_o = |eligible;

endmodule

// File: rtl/exc_kind_enc.sv
module exc_kind_enc
  import exc_pkg::*;
#(
  parameter int unsigned N = NUM_EXC
) (
  input  logic [N-1:0] grant_i,
  output exc_kind_e    kind_o
);

  always_comb begin
    kind_o = EX_RESET;
    for (int i = 0; i < N; i++) begin
      if (grant_i[i]) kind_o = exc_kind_e'(i);
    end
  end

endmodule

// File: rtl/exc_bundle_calc.sv
module exc_bundle_calc
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  exc_kind_e         kind_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   next_pc_i,
  input  logic              hivec_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   saved_o,
  output logic [XLEN-1:0]   link_o,
  output logic [XLEN-1:0]   vector_o
);

  localparam logic [XLEN-1:0] HI_BASE  = {{(XLEN-16){1'b1}}, 16'h0000};
  localparam logic [XLEN-1:0] WORD_INC = XLEN'(4);

  logic              is_reset;
  logic [XLEN-1:0]   base;
  logic [MODE_W-1:0] mode;

  assign is_reset = (kind_i == EX_RESET);
  assign mode     = target_mode(kind_i);
  assign base     = hivec_i ? HI_BASE : '0;

  always_comb begin
    status_o                = status_i;
    status_o[MODE_W-1:0]    = mode;
    status_o[ST_T]          = 1'b0;
    status_o[ST_I]          = 1'b1;
    if (masks_fast(kind_i)) status_o[ST_F] = 1'b1;
  end

  always_comb begin
    if (is_reset)                    link_o = '0;
    else if (link_adds_word(kind_i)) link_o = next_pc_i + WORD_INC;
    else                             link_o = next_pc_i;
  end

  assign saved_o  = is_reset ? '0 : status_i;
  assign vector_o = base | {{(XLEN-SLOT_W-2){1'b0}}, vector_slot(kind_i), 2'b00};
  assign mode_o   = mode;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary_i,
  input  logic [NUM_EXC-1:0]  req_i,
  input  logic [XLEN-1:0]     status_i,
  input  logic [XLEN-1:0]     next_pc_i,
  input  logic                hivec_i,
  output logic                entry_valid_o,
  output logic [NUM_EXC-1:0]  ack_o,
  output logic [MODE_W-1:0]   new_mode_o,
  output logic [XLEN-1:0]     new_status_o,
  output logic [XLEN-1:0]     saved_status_o,
  output logic [XLEN-1:0]     link_o,
  output logic [XLEN-1:0]     vector_o
);

  logic [NUM_EXC-1:0] grant;
  logic               take;
  exc_kind_e          kind;
  logic [MODE_W-1:0]  c_mode;
  logic [XLEN-1:0]    c_status, c_saved, c_link, c_vector;

  exc_prio_arb #(.N(NUM_EXC)) u_arb (
    .req_i         (req_i),
    .boundary_i    (boundary_i),
    .busy_i        (entry_valid_o),
    .fast_masked_i (status_i[ST_F]),
    .norm_masked_i (status_i[ST_I]),
    .grant_o       (grant),
    .any_o         (take)
  );

  exc_kind_enc #(.N(NUM_EXC)) u_enc (
    .grant_i (grant),
    .kind_o  (kind)
  );

  exc_bundle_calc #(.XLEN(XLEN)) u_calc (
    .kind_i    (kind),
    .status_i  (status_i),
    .next_pc_i (next_pc_i),
    .hivec_i   (hivec_i),
    .mode_o    (c_mode),
    .status_o  (c_status),
    .saved_o   (c_saved),
    .link_o    (c_link),
    .vector_o  (c_vector)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_valid_o  <= 1'b0;
      ack_o          <= '0;
      new_mode_o     <= '0;
      new_status_o   <= '0;
      saved_status_o <= '0;
      link_o         <= '0;
      vector_o       <= '0;
    end else begin
      entry_valid_o <= take;
      ack_o         <= grant;
      if (take) begin
        new_mode_o     <= c_mode;
        new_status_o   <= c_status;
        saved_status_o <= c_saved;
        link_o         <= c_link;
        vector_o       <= c_vector;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boundary_i,
  input logic [XLEN-1:0]    status_i,
  input logic               hivec_i,
  input logic               entry_valid_o,
  input logic [NUM_EXC-1:0] ack_o,
  input logic [MODE_W-1:0]  new_mode_o,
  input logic [XLEN-1:0]    new_status_o,
  input logic [XLEN-1:0]    saved_status_o,
  input logic [XLEN-1:0]    vector_o
);

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid_o |-> $countones(ack_o) == 1);

  a_r2_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_valid_o |-> ack_o == '0);

  a_r4_one_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid_o |=> !entry_valid_o);

  a_r4_reset_only_off_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && !$past(boundary_i)) |-> ack_o[EX_RESET]);

  a_r3_fast_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && ack_o[EX_FIQ]) |-> !$past(status_i[ST_F]));

  a_r3_norm_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && ack_o[EX_IRQ]) |-> !$past(status_i[ST_I]));

  a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid_o |-> new_status_o[XLEN-1:8] == $past(status_i[XLEN-1:8]));

  a_r9_state_bits: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid_o |-> (new_status_o[ST_I] && !new_status_o[ST_T]
                       && new_status_o[MODE_W-1:0] == new_mode_o));

  a_r5_base: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid_o |-> vector_o[XLEN-1:16] == ($past(hivec_i) ? {(XLEN-16){1'b1}} : {(XLEN-16){1'b0}}));

  a_r8_reset_clears_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && ack_o[EX_RESET]) |-> saved_status_o == '0);

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .boundary_i     (boundary_i),
  .status_i       (status_i),
  .hivec_i        (hivec_i),
  .entry_valid_o  (entry_valid_o),
  .ack_o          (ack_o),
  .new_mode_o     (new_mode_o),
  .new_status_o   (new_status_o),
  .saved_status_o (saved_status_o),
  .vector_o       (vector_o)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0;
  logic [6:0]  req_i = '0;
  logic [31:0] status_i = '0;
  logic [31:0] next_pc_i = '0;
  logic        hivec_i = 1'b0;
  logic        entry_valid_o;
  logic [6:0]  ack_o;
  logic [4:0]  new_mode_o;
  logic [31:0] new_status_o, saved_status_o, link_o, vector_o;

  int checks = 0;
  int fails  = 0;
  bit exp_busy = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_i(req_i),
    .status_i(status_i), .next_pc_i(next_pc_i), .hivec_i(hivec_i),
    .entry_valid_o(entry_valid_o), .ack_o(ack_o), .new_mode_o(new_mode_o),
    .new_status_o(new_status_o), .saved_status_o(saved_status_o),
    .link_o(link_o), .vector_o(vector_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic b, input logic [6:0] r, input logic [31:0] st,
                       input logic [31:0] pc, input logic hv, input bit busy,
                       output bit v, output logic [6:0] a, output logic [4:0] m,
                       output logic [31:0] ns, output logic [31:0] sv,
                       output logic [31:0] lk, output logic [31:0] vc);
    logic [6:0] e;
    logic [31:0] off;
    bit plus4, fset;
    e = r;
    if (!b) e = e & 7'b0000001;         // R4
    if (st[6]) e[2] = 1'b0;             // R3
    if (st[7]) e[3] = 1'b0;             // R3
    if (busy) e = '0;                   // R4
    a = '0;
    for (int i = 0; i < 7; i++) begin
      if (e[i] && a == '0) a[i] = 1'b1;
    end
    v = (a != '0);
    plus4 = 1'b0; fset = 1'b0; off = 32'h0; m = 5'h13;
    case (a)
      7'b0000001: begin m = 5'h13; off = 32'h00; fset = 1'b1; end
      7'b0000010: begin m = 5'h17; off = 32'h10; plus4 = 1'b1; end
      7'b0000100: begin m = 5'h11; off = 32'h1C; plus4 = 1'b1; fset = 1'b1; end
      7'b0001000: begin m = 5'h12; off = 32'h18; plus4 = 1'b1; end
      7'b0010000: begin m = 5'h17; off = 32'h0C; end
      7'b0100000: begin m = 5'h1B; off = 32'h04; end
      default:    begin m = 5'h13; off = 32'h08; end
    endcase
    vc = (hv ? 32'hFFFF0000 : 32'h0) + off;
    lk = a[0] ? 32'h0 : (plus4 ? pc + 32'd4 : pc);
    sv = a[0] ? 32'h0 : st;
    ns = {st[31:8], 1'b1, (fset ? 1'b1 : st[6]), 1'b0, m};
  endtask

  task automatic apply(input logic b, input logic [6:0] r, input logic [31:0] st,
                       input logic [31:0] pc, input logic hv);
    bit v;
    logic [6:0] a;
    logic [4:0] m;
    logic [31:0] ns, sv, lk, vc;
    boundary_i = b; req_i = r; status_i = st; next_pc_i = pc; hivec_i = hv;
    model(b, r, st, pc, hv, exp_busy, v, a, m, ns, sv, lk, vc);
    @(posedge clk);
    #1;
    chk(entry_valid_o == v, "R4 valid", {31'h0, entry_valid_o}, {31'h0, v});
    chk(ack_o == a, "R2 R3 ack", {25'h0, ack_o}, {25'h0, a});
    if (v && entry_valid_o) begin
      chk(vector_o == vc, "R5 vector", vector_o, vc);
      chk(new_mode_o == m, "R6 mode", {27'h0, new_mode_o}, {27'h0, m});
      chk(link_o == lk, "R7 link", link_o, lk);
      chk(saved_status_o == sv, "R8 saved", saved_status_o, sv);
      chk(new_status_o[7:0] == ns[7:0], "R9 status low", new_status_o, ns);
      chk(new_status_o[31:8] == ns[31:8], "R10 status flags", new_status_o, ns);
    end
    exp_busy = v;
  endtask

  task automatic idle();
    apply(1'b0, 7'h00, 32'h0, 32'h0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(entry_valid_o == 1'b0 && ack_o == '0, "R1 reset valid/ack", {24'h0, entry_valid_o, ack_o}, 32'h0);
    chk(new_status_o == '0 && saved_status_o == '0, "R1 reset status", new_status_o | saved_status_o, 32'h0);
    chk(link_o == '0 && vector_o == '0 && new_mode_o == '0, "R1 reset link/vector", link_o | vector_o, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: every request pending, reset wins
    apply(1'b1, 7'h7F, 32'hA000_0010, 32'h0000_1000, 1'b0);
    idle();
    // R2: all but reset, data abort wins
    apply(1'b1, 7'h7E, 32'h5000_0010, 32'h0000_2000, 1'b1);
    idle();
    // R3: fast interrupt masked, normal interrupt taken
    apply(1'b1, 7'h1C, 32'h0000_0050, 32'h0000_3000, 1'b0);
    idle();
    // R3: both interrupts masked, prefetch abort taken
    apply(1'b1, 7'h1C, 32'h0000_00D0, 32'h0000_3004, 1'b0);
    idle();
    // R3: both masked, nothing else pending
    apply(1'b1, 7'h0C, 32'hF000_00C0, 32'h0000_3008, 1'b0);
    chk(entry_valid_o == 1'b0, "R3 masked interrupts ignored", {31'h0, entry_valid_o}, 32'h0);
    // R4: software interrupt without strobe ignored, reset without strobe taken
    apply(1'b0, 7'h40, 32'h0000_0010, 32'h0000_4000, 1'b0);
    chk(entry_valid_o == 1'b0, "R4 no strobe no entry", {31'h0, entry_valid_o}, 32'h0);
    apply(1'b0, 7'h41, 32'h0000_0010, 32'h0000_4000, 1'b1);
    idle();
    // R4: held request with strobe on consecutive cycles
    apply(1'b1, 7'h40, 32'h2000_0010, 32'h0000_5000, 1'b0);
    apply(1'b1, 7'h40, 32'h2000_0010, 32'h0000_5000, 1'b0);
    chk(entry_valid_o == 1'b0, "R4 busy cycle blocks entry", {31'h0, entry_valid_o}, 32'h0);
    apply(1'b1, 7'h40, 32'h2000_0010, 32'h0000_5000, 1'b0);
    idle();
    // R5 R6 R7 R8 R9: each kind alone, both straps
    for (int k = 0; k < 7; k++) begin
      for (int h = 0; h < 2; h++) begin
        apply(1'b1, 7'(1 << k), 32'hC3A5_5A20 ^ 32'(k), 32'h0001_0000 + 32'(k * 16), h[0]);
        idle();
      end
    end
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] r;
      r = 7'($urandom) & 7'($urandom) & 7'b1111110;
      if (($urandom % 16) == 0) r[0] = 1'b1;
      apply(1'($urandom), r, $urandom, $urandom & 32'hFFFF_FFFC, 1'($urandom));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule